// File: doc/BRIEF.md
# Configurable Serial Shifter with Word Buffer

This block pairs a shift register with a one-word holding buffer so that a timer elsewhere in the chip can move asynchronous serial characters on a single pin. A mode input chooses the role. As a transmitter it takes a word written into the buffer, frames it with optional start and stop bits of programmable level, and drives it onto the pin least significant bit first. As a receiver it samples the pin, checks the framing bits and drops the finished character into the buffer. The timer supplies a shift clock and a level that is high while it is running. The shifter acts on one selectable edge of that clock.

A single status flag reports that the buffer is empty in transmit mode and full in receive mode, so the same flag can start the timer or raise a request. An error flag collects overruns on both sides and framing mismatches on receive. Software clears it by writing a one to it. A received character sits in the top byte of the buffer, and a byte-swapped view of the buffer puts it in the bottom byte.

Top module: `serial_shifter`

## Requirements
- R1: After reset the pin output is high, the error flag is low, and the status flag equals `cfg_tx` (buffer empty in transmit mode, not full in receive mode). `pin_oe` equals `cfg_tx`.
- R2: In transmit mode the frame starts on the first selected shift edge at which `tmr_active` is high and the buffer holds a word. Each later edge ends the current bit. The pin shows, in order, the start bit (`cfg_start_val`, if `cfg_start_en`), bits 0 to DATA_W-1 of the word, and the stop bit (`cfg_stop_val`, if `cfg_stop_en`). Outside a frame the pin is high.
- R3: In transmit mode a write fills the buffer and drops the status flag. Moving the word into the shifter when a frame starts raises the status flag.
- R4: In receive mode the first edge with `tmr_active` high arms the shifter. Each later edge samples one bit in the same order as R2. At the last bit the character is stored in buffer bits [31:24] and in `rd_data_swap` bits [7:0], and the status flag rises. A read clears it.
- R5: In receive mode, a sampled start or stop bit whose level differs from the configured level sets the error flag.
- R6: A received word that completes while the status flag is set, with no read in that cycle, sets the error flag and replaces the buffered word.
- R7: A transmit write while the buffer still holds an unsent word, with no frame start in that cycle, sets the error flag, and the newer word is the one sent.
- R8: With `cfg_fall_edge` high, only falling edges of `tmr_shift_clk` act and rising edges have no effect. With it low, only rising edges act.
- R9: Writing one to `error_clr` clears the error flag, except that a new error in the same cycle leaves it set.
- R10: A read in the same cycle as a receive completion returns the older word, leaves the status flag set for the new word, and raises no error.
- R11: A transmit write in the same cycle as a frame start sends the older word, keeps the newer one buffered with status low, and raises no error.
- R12: `wr_en` in receive mode and `rd_en` in transmit mode have no effect on the buffer or the flags.
- R13: If a frame start is allowed at the edge that ends the last bit, the next frame's first bit follows with no idle bit between the frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_tx | input | 1 | 1 = transmit role, 0 = receive role |
| cfg_start_en | input | 1 | Frame carries a start bit |
| cfg_start_val | input | 1 | Level of the start bit |
| cfg_stop_en | input | 1 | Frame carries a stop bit |
| cfg_stop_val | input | 1 | Level of the stop bit |
| cfg_fall_edge | input | 1 | 1 = act on falling shift-clock edges, 0 = rising |
| tmr_shift_clk | input | 1 | Shift clock from the timer, synchronous to clk |
| tmr_active | input | 1 | Timer running; allows a frame to start |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | BUF_W | Word to transmit |
| rd_en | input | 1 | Buffer read strobe |
| rd_data | output | BUF_W | Buffer contents |
| rd_data_swap | output | BUF_W | Buffer contents with byte order reversed |
| pin_in | input | 1 | Serial input line |
| pin_out | output | 1 | Serial output line |
| pin_oe | output | 1 | Output enable for the line |
| status_flag | output | 1 | Buffer empty (transmit) or full (receive) |
| error_flag | output | 1 | Overrun or framing error |
| error_clr | input | 1 | Write one to clear the error flag |

## Verification
The interesting collision is between software access to the buffer and the shifter's own access at a frame boundary. On receive, the read strobe is raised on exactly the clock edge at which the shift edge for the final bit is seen. On transmit, a write is raised on the edge that starts a frame. The bench samples `rd_data` just before that edge and expects the older word. After the edge it expects the status flag set on receive or clear on transmit, with the error flag still low. The newer word must then follow in the next read or on the pin.

// File: rtl/sshift_pkg.sv
// Shared types for the serial shifter: which part of a frame the
// current bit belongs to.
package sshift_pkg;
    typedef enum logic [1:0] {
        PH_START = 2'd0,
        PH_DATA  = 2'd1,
        PH_STOP  = 2'd2
    } bit_phase_e;
endpackage

// File: rtl/sshift_edge.sv
// Shift-clock edge selector.
// Turns the timer's shift clock into a one-cycle step strobe on the chosen
// edge. Assumes the shift clock is generated in the clk domain and stays
// low through reset.
module sshift_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_clk,
    input  logic use_fall,
    output logic step
);
    logic sclk_q;

    // Hold last shift-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= shift_clk;
    end

    // Pick rising or falling transition.
    always_comb begin
        if (use_fall) step = sclk_q & ~shift_clk;
        else          step = ~sclk_q & shift_clk;
    end
endmodule

// File: rtl/sshift_seq.sv
// Frame bit sequencer.
// Tracks the bit position inside a frame of optional start bit, DATA_W data
// bits and optional stop bit. A step while idle (or while ending the last
// bit) with go high engages a frame; every other step while busy closes the
// current bit. Assumes the framing options stay fixed during a frame.
module sshift_seq
    import sshift_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       go,
    input  logic       start_en,
    input  logic       stop_en,
    output logic       busy,
    output logic       engage,
    output logic       close,
    output logic       last,
    output bit_phase_e phase
);
    localparam int IDX_W = $clog2(DATA_W + 2);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = IDX_W'(DATA_W - 1) + IDX_W'(start_en) + IDX_W'(stop_en);
    assign last     = busy & (idx_q == last_idx);
    assign close    = step & busy;
    assign engage   = step & go & (~busy | last);

    // Advance the bit position and the busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            idx_q <= '0;
        end else if (engage) begin
            busy  <= 1'b1;
            idx_q <= '0;
        end else if (close) begin
            if (last) busy <= 1'b0;
            else      idx_q <= idx_q + 1'b1;
        end
    end

    // Classify the current bit.
    always_comb begin
        if (start_en && idx_q == '0)           phase = PH_START;
        else if (stop_en && idx_q == last_idx) phase = PH_STOP;
        else                                   phase = PH_DATA;
    end
endmodule

// File: rtl/serial_shifter.sv
// Serial shifter with one-word buffer.
// Transmit: the buffered word is framed and shifted out LSB first. Receive:
// the line is sampled and the character lands in the top DATA_W bits of the
// buffer. One status flag (empty on transmit, full on receive) and one sticky
// error flag (overrun, framing) cleared by writing one.
// Assumes cfg_* change only while no frame is in progress, DATA_W >= 2,
// DATA_W <= BUF_W and BUF_W a multiple of 8.
module serial_shifter
    import sshift_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BUF_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_tx,
    input  logic             cfg_start_en,
    input  logic             cfg_start_val,
    input  logic             cfg_stop_en,
    input  logic             cfg_stop_val,
    input  logic             cfg_fall_edge,
    input  logic             tmr_shift_clk,
    input  logic             tmr_active,
    input  logic             wr_en,
    input  logic [BUF_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [BUF_W-1:0] rd_data,
    output logic [BUF_W-1:0] rd_data_swap,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             status_flag,
    output logic             error_flag,
    input  logic             error_clr
);
    localparam int PAD_W  = BUF_W - DATA_W;
    localparam int NBYTES = BUF_W / 8;

    logic              step, busy, engage, close, last;
    bit_phase_e        phase;
    logic [BUF_W-1:0]  buf_q;
    logic              buf_full;
    logic [DATA_W-1:0] sh_q, rx_word;
    logic              err_q, go, line_bit;
    logic              tx_load, tx_write, tx_overrun;
    logic              rx_close, rx_done, rx_overrun, bad_frame, err_set;

    sshift_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_clk (tmr_shift_clk),
        .use_fall  (cfg_fall_edge),
        .step      (step)
    );

    sshift_seq #(.DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .go       (go),
        .start_en (cfg_start_en),
        .stop_en  (cfg_stop_en),
        .busy     (busy),
        .engage   (engage),
        .close    (close),
        .last     (last),
        .phase    (phase)
    );

    // Frame start condition and the events derived from the sequencer.
    assign go         = cfg_tx ? (tmr_active & buf_full) : tmr_active;
    assign tx_load    = cfg_tx & engage;
    assign tx_write   = cfg_tx & wr_en;
    assign tx_overrun = tx_write & buf_full & ~tx_load;
    assign rx_close   = ~cfg_tx & close;
    assign rx_done    = rx_close & last;
    assign rx_overrun = rx_done & buf_full & ~rd_en;
    assign err_set    = bad_frame | rx_overrun | tx_overrun;

    // Received word including the bit being sampled now.
    assign rx_word = (phase == PH_DATA) ? {pin_in, sh_q[DATA_W-1:1]} : sh_q;

    // Framing check on sampled start and stop bits.
    always_comb begin
        bad_frame = 1'b0;
        if (rx_close && phase == PH_START && pin_in != cfg_start_val) bad_frame = 1'b1;
        if (rx_close && phase == PH_STOP  && pin_in != cfg_stop_val)  bad_frame = 1'b1;
    end

    // Level driven while a transmit frame is on the line.
    always_comb begin
        case (phase)
            PH_START: line_bit = cfg_start_val;
            PH_STOP:  line_bit = cfg_stop_val;
            default:  line_bit = sh_q[0];
        endcase
    end

    assign pin_out = (cfg_tx & busy) ? line_bit : 1'b1;
    assign pin_oe  = cfg_tx;

    // Shift register: load on transmit start, move one place per data bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else if (tx_load)
            sh_q <= buf_q[DATA_W-1:0];
        else if (close && phase == PH_DATA)
            sh_q <= cfg_tx ? (sh_q >> 1) : rx_word;
    end

    // Buffer contents: software write on transmit, capture on receive.
    always_ff @(posedge clk) begin
        if (!rst_n)        buf_q <= '0;
        else if (tx_write) buf_q <= wr_data;
        else if (rx_done)  buf_q <= BUF_W'(rx_word) << PAD_W;
    end

    // Buffer occupancy; filling wins over emptying in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            buf_full <= 1'b0;
        else if (tx_write || rx_done)
            buf_full <= 1'b1;
        else if (tx_load || (!cfg_tx && rd_en))
            buf_full <= 1'b0;
    end

    // Sticky error flag, write one to clear, new errors win.
    always_ff @(posedge clk) begin
        if (!rst_n)         err_q <= 1'b0;
        else if (err_set)   err_q <= 1'b1;
        else if (error_clr) err_q <= 1'b0;
    end

    assign status_flag = cfg_tx ? ~buf_full : buf_full;
    assign error_flag  = err_q;
    assign rd_data     = buf_q;

    // Byte-reversed view of the buffer.
    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign rd_data_swap[8*b +: 8] = buf_q[8*(NBYTES-1-b) +: 8];
    end
endmodule

// File: rtl/sshift_checker.sv
// Property checker for serial_shifter, attached by bind. Observes the
// ports and the internal frame start, completion and error-set strobes.
module sshift_checker (
    input logic clk,
    input logic rst_n,
    input logic mode_tx,
    input logic wr_en,
    input logic rd_en,
    input logic err_clr,
    input logic status,
    input logic err,
    input logic rx_done,
    input logic tx_load,
    input logic err_set
);
    // R3: a transmit write leaves the buffer full.
    a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_tx && wr_en) |=> (!status || !mode_tx));

    // R4: a receive read with no completion empties the buffer.
    a_r4_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_tx && rd_en && !rx_done) |=> (!status || mode_tx));

    // R6: completion onto an unread word flags an error.
    a_r6_rx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_tx && rx_done && status && !rd_en) |=> err);

    // R7: writing over an unsent word flags an error.
    a_r7_tx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_tx && wr_en && !status && !tx_load) |=> err);

    // R9: a clear with no new error drops the flag.
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !err_set) |=> !err);

    // R10: completion leaves the receive status set even with a read.
    a_r10_done_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_tx && rx_done) |=> (status || mode_tx));
endmodule

bind serial_shifter sshift_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_tx (cfg_tx),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .err_clr (error_clr),
    .status  (status_flag),
    .err     (error_flag),
    .rx_done (rx_done),
    .tx_load (tx_load),
    .err_set (err_set)
);

// File: tb/tb_serial_shifter.sv
// Bench for serial_shifter: a vector table of frames walked by one loop,
// then directed tests for reset, overruns, clears and same-cycle collisions.
module tb_serial_shifter;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_tx = 1'b1, cfg_start_en = 1'b1, cfg_start_val = 1'b0;
    logic        cfg_stop_en = 1'b1, cfg_stop_val = 1'b1, cfg_fall_edge = 1'b0;
    logic        tmr_shift_clk = 1'b0, tmr_active = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, pin_in = 1'b1, error_clr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data, rd_data_swap;
    logic        pin_out, pin_oe, status_flag, error_flag;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    serial_shifter dut (
        .clk(clk), .rst_n(rst_n), .cfg_tx(cfg_tx),
        .cfg_start_en(cfg_start_en), .cfg_start_val(cfg_start_val),
        .cfg_stop_en(cfg_stop_en), .cfg_stop_val(cfg_stop_val),
        .cfg_fall_edge(cfg_fall_edge), .tmr_shift_clk(tmr_shift_clk),
        .tmr_active(tmr_active), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rd_data_swap(rd_data_swap),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .status_flag(status_flag), .error_flag(error_flag),
        .error_clr(error_clr)
    );

    always #5 clk = ~clk;

    // Vector: tx, fall, sen, sval, pen, pval, bad, data[7:0]
    localparam logic [14:0] VEC [0:8] = '{
        15'b1_0_1_0_1_1_0_10100101,
        15'b1_1_0_0_1_1_0_00111100,
        15'b1_0_1_1_0_0_0_10000001,
        15'b1_1_0_0_0_0_0_01011110,
        15'b0_0_1_0_1_1_0_11000011,
        15'b0_1_1_0_1_1_0_01111110,
        15'b0_0_1_0_1_1_1_00010001,
        15'b0_0_1_1_0_0_1_10011010,
        15'b0_1_0_0_0_0_0_11100111
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // One full shift-clock period: a rising then a falling edge.
    task automatic edge_once();
        tmr_shift_clk = 1'b1;
        cyc();
        tmr_shift_clk = 1'b0;
        cyc();
    endtask

    task automatic set_cfg(input logic tx, fall, sen, sval, pen, pval);
        cfg_tx = tx; cfg_fall_edge = fall; cfg_start_en = sen;
        cfg_start_val = sval; cfg_stop_en = pen; cfg_stop_val = pval;
        cyc();
    endtask

    // Expected line bits of a frame; returns the bit count.
    function automatic int build(input logic sen, sval, pen, pval,
                                 input logic [7:0] d, output logic [9:0] bits);
        int n = 0;
        bits = '0;
        if (sen) begin bits[n] = sval; n++; end
        for (int i = 0; i < 8; i++) begin bits[n] = d[i]; n++; end
        if (pen) begin bits[n] = pval; n++; end
        return n;
    endfunction

    task automatic tx_write(input logic [31:0] w);
        wr_data = w; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
    endtask

    // Send the buffered word and check every bit on the pin (R2, R3).
    task automatic tx_frame(input logic [7:0] d);
        logic [9:0] bits;
        int n = build(cfg_start_en, cfg_start_val, cfg_stop_en, cfg_stop_val, d, bits);
        tmr_active = 1'b1;
        edge_once();
        tmr_active = 1'b0;
        check("R3 status after frame start", status_flag, 1'b1);
        check("R2 pin_oe in transmit", pin_oe, 1'b1);
        for (int k = 0; k < n; k++) begin
            if (k > 0) edge_once();
            check("R2 transmit bit", pin_out, bits[k]);
        end
        edge_once();
        check("R2 line idles high", pin_out, 1'b1);
    endtask

    // Feed one frame to the receiver; optionally read on the final edge (R10).
    task automatic rx_frame(input logic [7:0] d, input logic bad,
                            input logic rd_last, input logic [7:0] old_top);
        logic [9:0] bits;
        int n = build(cfg_start_en, cfg_start_val, cfg_stop_en, cfg_stop_val, d, bits);
        if (bad) begin
            if (cfg_stop_en) bits[n-1] = ~bits[n-1];
            else             bits[0]   = ~bits[0];
        end
        pin_in = 1'b1;
        tmr_active = 1'b1;
        edge_once();
        tmr_active = 1'b0;
        for (int k = 0; k < n; k++) begin
            pin_in = bits[k];
            if (k == n - 1 && rd_last) begin
                tmr_shift_clk = 1'b1;
                rd_en = 1'b1;
                #1;
                check("R10 read returns older word", rd_data[31:24], old_top);
                cyc();
                rd_en = 1'b0;
                tmr_shift_clk = 1'b0;
                cyc();
            end else begin
                edge_once();
            end
        end
        pin_in = 1'b1;
    endtask

    task automatic pulse_clr();
        error_clr = 1'b1;
        cyc();
        error_clr = 1'b0;
    endtask

    task automatic pulse_rd();
        rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [9:0] bits;
        int n;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1: reset state in both roles
        check("R1 pin high after reset", pin_out, 1'b1);
        check("R1 error low after reset", error_flag, 1'b0);
        check("R1 transmit status empty", status_flag, 1'b1);
        check("R1 pin_oe transmit", pin_oe, 1'b1);
        cfg_tx = 1'b0;
        cyc();
        check("R1 receive status clear", status_flag, 1'b0);
        check("R1 pin_oe receive", pin_oe, 1'b0);

        // Vector table: R2, R4, R5, R8 over framings and both edges
        for (int v = 0; v < 9; v++) begin
            logic [14:0] e = VEC[v];
            set_cfg(e[14], e[13], e[12], e[11], e[10], e[9]);
            if (e[14]) begin
                tx_write({24'h0, e[7:0]});
                check("R3 status after write", status_flag, 1'b0);
                tx_frame(e[7:0]);
                check("R2 no error on transmit", error_flag, 1'b0);
            end else begin
                rx_frame(e[7:0], e[8], 1'b0, 8'h00);
                check("R4 status on completion", status_flag, 1'b1);
                if (!e[8]) begin
                    check("R4 top byte", rd_data[31:24], e[7:0]);
                    check("R4 swapped low byte", rd_data_swap[7:0], e[7:0]);
                end
                check("R5 framing error flag", error_flag, e[8]);
                pulse_rd();
                check("R4 read clears status", status_flag, 1'b0);
                pulse_clr();
                check("R9 clear", error_flag, 1'b0);
            end
        end

        // R7 and R9: overwrite an unsent word, clear in the same cycle
        set_cfg(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        tx_write(32'h0000_0011);
        error_clr = 1'b1;
        tx_write(32'h0000_00C6);
        error_clr = 1'b0;
        check("R9 new error wins over clear", error_flag, 1'b1);
        check("R7 status still full", status_flag, 1'b0);
        // R12: read strobe in transmit mode does nothing
        pulse_rd();
        check("R12 rd_en ignored in transmit", status_flag, 1'b0);
        tx_frame(8'hC6);
        check("R7 newest word sent, error kept", error_flag, 1'b1);
        pulse_clr();
        check("R9 clear after overrun", error_flag, 1'b0);

        // R11 and R13: write during frame start, then back-to-back frames
        tx_write(32'h0000_0035);
        tmr_active = 1'b1;
        tmr_shift_clk = 1'b1;
        wr_data = 32'h0000_00CA;
        wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
        tmr_shift_clk = 1'b0;
        cyc();
        check("R11 no error on write at start", error_flag, 1'b0);
        check("R11 newer word held", status_flag, 1'b0);
        n = build(1'b1, 1'b0, 1'b1, 1'b1, 8'h35, bits);
        for (int k = 0; k < n; k++) begin
            if (k > 0) edge_once();
            check("R11 older word on the pin", pin_out, bits[k]);
        end
        edge_once();
        tmr_active = 1'b0;
        check("R13 next start bit without gap", pin_out, 1'b0);
        check("R13 buffer emptied by second start", status_flag, 1'b1);
        n = build(1'b1, 1'b0, 1'b1, 1'b1, 8'hCA, bits);
        for (int k = 1; k < n; k++) begin
            edge_once();
            check("R13 second word bit", pin_out, bits[k]);
        end
        edge_once();
        check("R13 idle after second frame", pin_out, 1'b1);

        // R8: falling-edge mode ignores a rising edge
        set_cfg(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        tx_write(32'h0000_00F0);
        tmr_active = 1'b1;
        tmr_shift_clk = 1'b1;
        cyc();
        cyc();
        check("R8 rising edge ignored: status", status_flag, 1'b0);
        check("R8 rising edge ignored: pin", pin_out, 1'b1);
        tmr_shift_clk = 1'b0;
        cyc();
        tmr_active = 1'b0;
        check("R8 falling edge starts frame", pin_out, 1'b0);
        for (int k = 0; k < 10; k++) edge_once();
        check("R8 frame ends", pin_out, 1'b1);

        // R6 receive overrun, R12 write ignored in receive
        set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        rx_frame(8'h4B, 1'b0, 1'b0, 8'h00);
        tx_write(32'hDEAD_BEEF);
        check("R12 wr_en ignored in receive", rd_data[31:24], 8'h4B);
        check("R12 status kept", status_flag, 1'b1);
        rx_frame(8'hB2, 1'b0, 1'b0, 8'h00);
        check("R6 overrun error", error_flag, 1'b1);
        check("R6 newer word stored", rd_data[31:24], 8'hB2);
        pulse_rd();
        pulse_clr();

        // R10: read on the completing edge
        rx_frame(8'h66, 1'b0, 1'b0, 8'h00);
        rx_frame(8'h99, 1'b0, 1'b1, 8'h66);
        check("R10 status stays set", status_flag, 1'b1);
        check("R10 no overrun error", error_flag, 1'b0);
        check("R10 new word in buffer", rd_data[31:24], 8'h99);
        pulse_rd();
        check("R4 status clear after read", status_flag, 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule